// File: doc/BRIEF.md
# Data-Processing Instruction Execute Unit

This block takes one 32-bit data-processing instruction word and executes it in a single cycle. A decoder pulls the register indices, the operation code, the flag-set bit and the operand form out of the word. The second operand is either the value read from the Rm register or an 8-bit constant rotated right inside a 32-bit word. A sixteen-way ALU then produces the result and the candidate condition flags.

The surrounding pipeline owns the register file. It reads the two source registers at the indices this block reports and feeds their values back. When the write enable is high, it stores the result at the destination index. The only state held here is the four-bit condition flag register. That register supplies the incoming carry for the carry-chained operations and is updated at the clock edge that ends each accepted instruction.

Instruction field layout: bits [27:26] must be 00 for the instruction to be supported. Bit 25 selects the immediate form. Bits [24:21] are the operation code, bit 20 is the flag-set bit, bits [19:16] are Rn and bits [15:12] are Rd. In the register form, bits [3:0] are Rm. In the immediate form, bits [11:8] are the rotate amount and bits [7:0] are the constant. Bits [31:28] carry the always-execute condition and are not examined.

Top module: `dp_exec_unit`

## Requirements
- R1: `rn_idx`, `rd_idx` and `rm_idx` always equal instruction bits [19:16], [15:12] and [3:0].
- R2: With bit 25 set, the second operand is bits [7:0] rotated right by twice bits [11:8], wrapping low bits into the top. Constant 30 with rotate 13 gives 1920.
- R3: With bit 25 clear, the second operand is `rm_val`. Word 0xE0810003 gives Rd=0, Rn=1, Rm=3 and the result R1+R3. Word 0xE26A7031 gives Rd=7, Rn=10 and the result 49 minus R10.
- R4: Logical codes: 0000 gives a AND b, 0001 gives a XOR b, 1100 gives a OR b, 1110 gives a AND NOT b, 1101 gives b, and 1111 gives NOT b. Here a is `rn_val` and b is the second operand; the last two ignore a.
- R5: Arithmetic codes: 0100 gives a+b, 0101 gives a+b+C, 0010 gives a-b, 0110 gives a-b-(1-C), 0011 gives b-a, and 0111 gives b-a-(1-C). C is the stored carry flag.
- R6: Compare codes 1000, 1001, 1010 and 1011 compute AND, XOR, subtract and add. For these codes `wr_en` is low and the flags update even when bit 20 is clear.
- R7: For all other supported codes `wr_en` is high, and the flags update only when bit 20 is set.
- R8: The flags are `flags_nzcv` = {N,Z,C,V}. N is result bit 31 and Z is set when the result is zero. For add forms, C is the carry out; for subtract forms, C is NOT borrow. V reports signed overflow. Logical and bitwise-test codes keep the old C and V.
- R9: A valid word with bits [27:26] not equal to 00 raises `unsupported`, keeps `wr_en` low and leaves the flags unchanged.
- R10: Reset (`rst_n` low) clears `flags_nzcv` to 0000.
- R11: While `instr_valid` is low, `wr_en` and `unsupported` are low and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rn_val | input | 32 | Value read at `rn_idx` |
| rm_val | input | 32 | Value read at `rm_idx` |
| rn_idx | output | 4 | First source register index |
| rm_idx | output | 4 | Second source register index |
| rd_idx | output | 4 | Destination register index |
| wr_en | output | 1 | Destination write enable |
| result | output | 32 | ALU result |
| flags_nzcv | output | 4 | Stored condition flags {N,Z,C,V} |
| unsupported | output | 1 | Valid instruction outside the subset |

## Verification
The carry-chained operations read the stored carry and can overwrite it in the same cycle. An ADC or SBC with bit 20 set therefore consumes C and produces a new C at one clock edge. The bench provokes this with back-to-back flag-setting carry chains and with random runs where every operation follows every other. It judges the result with the old carry and the flags after the edge with the new carry, both against a behavioural model. Compare operations with bit 20 clear are mixed in to show that the flag update does not depend on that bit for them.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
      OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
      OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } alu_op_e;

   typedef struct packed {
      logic [3:0] rn;
      logic [3:0] rd;
      logic [3:0] rm;
      alu_op_e    op;
      logic       set_flags;
      logic       imm_form;
      logic [3:0] rot;
      logic [7:0] imm8;
      logic       unsupported;
   } dec_t;
endpackage

// File: rtl/dpx_decode.sv
module dpx_decode
   import dpx_pkg::*;
(
   input  logic [31:0] instr,
   output dec_t        dec
);
   logic [3:0] unused_cond;

   always_comb begin
      dec.rn          = instr[19:16];
      dec.rd          = instr[15:12];
      dec.rm          = instr[3:0];
      dec.op          = alu_op_e'(instr[24:21]);
      dec.set_flags   = instr[20];
      dec.imm_form    = instr[25];
      dec.rot         = instr[11:8];
      dec.imm8        = instr[7:0];
      dec.unsupported = (instr[27:26] != 2'b00);
   end

   assign unused_cond = instr[31:28];
endmodule

// File: rtl/dpx_imm_expand.sv
module dpx_imm_expand #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IMM_W    = 8,
   parameter int unsigned ROT_W    = 4,
   parameter int unsigned ROT_IMPL = 0   // 0: doubled-word shift, 1: log rotate stages
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic [ROT_W-1:0]  rot,
   output logic [DATA_W-1:0] value
);
   localparam int unsigned AMT_W = ROT_W + 1;

   if (IMM_W > DATA_W) begin : g_bad_imm
      $error("dpx_imm_expand: IMM_W wider than DATA_W");
   end
   if (2 * ((1 << ROT_W) - 1) >= DATA_W) begin : g_bad_rot
      $error("dpx_imm_expand: rotate range exceeds word width");
   end

   logic [DATA_W-1:0] base;
   assign base = {{(DATA_W-IMM_W){1'b0}}, imm};

   if (ROT_IMPL == 0) begin : g_dbl
      logic [AMT_W-1:0]    amt;
      logic [2*DATA_W-1:0] dbl;
      logic [2*DATA_W-1:0] shifted;
      assign amt     = {rot, 1'b0};
      assign dbl     = {base, base};
      assign shifted = dbl >> amt;
      assign value   = shifted[DATA_W-1:0];
   end else begin : g_stage
      logic [DATA_W-1:0] stage [ROT_W+1];
      assign stage[0] = base;
      for (genvar j = 0; j < ROT_W; j++) begin : g_rs
         localparam int unsigned SH = 2 << j;
         assign stage[j+1] = rot[j] ? {stage[j][SH-1:0], stage[j][DATA_W-1:SH]}
                                    : stage[j];
      end
      assign value = stage[ROT_W];
   end
endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
   import dpx_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              c_in,
   input  logic              v_in,
   output logic [DATA_W-1:0] res,
   output logic              n_out,
   output logic              z_out,
   output logic              c_out,
   output logic              v_out
);
   logic [DATA_W-1:0] x, y, logic_r;
   logic [DATA_W:0]   sum;
   logic              cin, is_arith;

   always_comb begin
      x        = a;
      y        = b;
      cin      = 1'b0;
      is_arith = 1'b1;
      logic_r  = '0;
      unique case (op)
         OP_AND, OP_TST: begin is_arith = 1'b0; logic_r = a & b;  end
         OP_EOR, OP_TEQ: begin is_arith = 1'b0; logic_r = a ^ b;  end
         OP_ORR:         begin is_arith = 1'b0; logic_r = a | b;  end
         OP_MOV:         begin is_arith = 1'b0; logic_r = b;      end
         OP_BIC:         begin is_arith = 1'b0; logic_r = a & ~b; end
         OP_MVN:         begin is_arith = 1'b0; logic_r = ~b;     end
         OP_ADD, OP_CMN: cin = 1'b0;
         OP_ADC:         cin = c_in;
         OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1; end
         OP_SBC:         begin y = ~b; cin = c_in; end
         OP_RSB:         begin x = b; y = ~a; cin = 1'b1; end
         OP_RSC:         begin x = b; y = ~a; cin = c_in; end
      endcase
      sum = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
   end

   assign res   = is_arith ? sum[DATA_W-1:0] : logic_r;
   assign n_out = res[DATA_W-1];
   assign z_out = (res == '0);
   assign c_out = is_arith ? sum[DATA_W] : c_in;
   assign v_out = is_arith ? ((x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]))
                           : v_in;
endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
   import dpx_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IMM_W    = 8,
   parameter int unsigned ROT_W    = 4,
   parameter int unsigned ROT_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] rm_val,
   output logic [3:0]        rn_idx,
   output logic [3:0]        rm_idx,
   output logic [3:0]        rd_idx,
   output logic              wr_en,
   output logic [DATA_W-1:0] result,
   output logic [3:0]        flags_nzcv,
   output logic              unsupported
);
   if (DATA_W != 32) begin : g_bad_w
      $error("dp_exec_unit: instruction encoding fixes DATA_W at 32");
   end
   if (IMM_W != 8 || ROT_W != 4) begin : g_bad_f
      $error("dp_exec_unit: immediate fields are fixed by the encoding");
   end

   dec_t              dec;
   logic [DATA_W-1:0] imm_val, op2;
   logic              n_nx, z_nx, c_nx, v_nx;
   logic              is_cmp, accepted, flag_upd;
   logic [3:0]        flags_q;

   dpx_decode i_dec (.instr(instr), .dec(dec));

   dpx_imm_expand #(
      .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .ROT_IMPL(ROT_IMPL)
   ) i_imm (
      .imm(dec.imm8), .rot(dec.rot), .value(imm_val)
   );

   assign op2 = dec.imm_form ? imm_val : rm_val;

   dpx_alu #(.DATA_W(DATA_W)) i_alu (
      .op(dec.op), .a(rn_val), .b(op2),
      .c_in(flags_q[1]), .v_in(flags_q[0]),
      .res(result), .n_out(n_nx), .z_out(z_nx), .c_out(c_nx), .v_out(v_nx)
   );

   assign is_cmp      = (dec.op[3:2] == 2'b10);
   assign accepted    = instr_valid && !dec.unsupported;
   assign wr_en       = accepted && !is_cmp;
   assign flag_upd    = accepted && (is_cmp || dec.set_flags);
   assign unsupported = instr_valid && dec.unsupported;
   assign rn_idx      = dec.rn;
   assign rm_idx      = dec.rm;
   assign rd_idx      = dec.rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_q <= 4'b0000;
      else if (flag_upd) flags_q <= {n_nx, z_nx, c_nx, v_nx};
   end
   assign flags_nzcv = flags_q;

   // R6
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr[27:26] == 2'b00 && instr[24:23] == 2'b10) |-> !wr_en);
   // R9
   unsup_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr[27:26] != 2'b00) |-> (unsupported && !wr_en));
   // R9
   unsup_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |=> $stable(flags_nzcv));
   // R11
   idle_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> $stable(flags_nzcv));
   // R7
   no_set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !instr[20]) |=> $stable(flags_nzcv));
   // R8
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_upd |=> (flags_nzcv[2] == ($past(result) == '0)));
   // R8
   neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_upd |=> (flags_nzcv[3] == $past(result[DATA_W-1])));
endmodule

// File: tb/test_dp_exec_unit.sv
module test_dp_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n, instr_valid;
   logic [31:0] instr, rn_val, rm_val, result;
   logic [3:0]  rn_idx, rm_idx, rd_idx, flags_nzcv;
   logic        wr_en, unsupported;
   int          total = 0, bad = 0;
   logic [3:0]  m_f = 4'b0000;

   always #2 clk = ~clk;

   dp_exec_unit i_dp_exec_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .rn_val(rn_val), .rm_val(rm_val), .rn_idx(rn_idx), .rm_idx(rm_idx),
      .rd_idx(rd_idx), .wr_en(wr_en), .result(result), .flags_nzcv(flags_nzcv),
      .unsupported(unsupported)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc(bit imm, logic [3:0] op, bit s,
                                       logic [3:0] rn, logic [3:0] rd, logic [11:0] low);
      return {4'hE, 2'b00, imm, op, s, rn, rd, low};
   endfunction

   function automatic logic [31:0] ror_imm(logic [7:0] k, logic [3:0] r);
      logic [31:0] v = {24'd0, k};
      for (int i = 0; i < 2 * int'(r); i++) v = {v[0], v[31:1]};
      return v;
   endfunction

   task automatic step(logic [31:0] ins, logic [31:0] a, logic [31:0] m, logic vld, string tag);
      logic [31:0] b, er;
      logic        ew, eu, upd, arith, cy, ov, cin, is_add;
      logic [3:0]  op, nf;
      longint      la, lb, sa, sb, full, sfull, bw;
      @(negedge clk);
      instr = ins; rn_val = a; rm_val = m; instr_valid = vld;
      #1;
      op  = ins[24:21];
      cin = m_f[1];
      bw  = cin ? 0 : 1;
      b   = ins[25] ? ror_imm(ins[7:0], ins[11:8]) : m;
      la = longint'(a); lb = longint'(b);
      sa = longint'($signed(a)); sb = longint'($signed(b));
      eu = vld && (ins[27:26] != 2'b00);
      arith = 1'b1; is_add = 1'b0; er = '0; full = 0; sfull = 0;
      case (op)
         4'd0, 4'd8:  begin arith = 0; er = a & b;  end
         4'd1, 4'd9:  begin arith = 0; er = a ^ b;  end
         4'd12:       begin arith = 0; er = a | b;  end
         4'd13:       begin arith = 0; er = b;      end
         4'd14:       begin arith = 0; er = a & ~b; end
         4'd15:       begin arith = 0; er = ~b;     end
         4'd4, 4'd11: begin is_add = 1; full = la + lb;        sfull = sa + sb;        end
         4'd5:        begin is_add = 1; full = la + lb + 1 - bw; sfull = sa + sb + 1 - bw; end
         4'd2, 4'd10: begin full = la - lb;      sfull = sa - sb;      end
         4'd6:        begin full = la - lb - bw; sfull = sa - sb - bw; end
         4'd3:        begin full = lb - la;      sfull = sb - sa;      end
         default:     begin full = lb - la - bw; sfull = sb - sa - bw; end
      endcase
      if (arith) begin
         er = full[31:0];
         cy = is_add ? (full >= 64'sh1_0000_0000) : (full >= 0);
         ov = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
         nf = {er[31], er == 32'd0, cy, ov};
      end else begin
         nf = {er[31], er == 32'd0, m_f[1:0]};
      end
      ew  = vld && !eu && (op[3:2] != 2'b10);
      upd = vld && !eu && ((op[3:2] == 2'b10) || ins[20]);
      chk("R1", "rn_idx", {28'd0, rn_idx}, {28'd0, ins[19:16]});
      chk("R1", "rd_idx", {28'd0, rd_idx}, {28'd0, ins[15:12]});
      chk("R1", "rm_idx", {28'd0, rm_idx}, {28'd0, ins[3:0]});
      chk(tag, "wr_en", {31'd0, wr_en}, {31'd0, ew});
      chk(tag, "unsupported", {31'd0, unsupported}, {31'd0, eu});
      if (vld && !eu) chk(tag, "result", result, er);
      @(posedge clk);
      #1;
      if (upd) m_f = nf;
      chk(tag, "flags", {28'd0, flags_nzcv}, {28'd0, m_f});
   endtask

   initial begin
      #400000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; instr_valid = 1'b0; instr = '0; rn_val = '0; rm_val = '0;
      repeat (3) @(negedge clk);
      chk("R10", "flags after reset", {28'd0, flags_nzcv}, 32'd0);
      rst_n = 1'b1;

      // R3 the two reference encodings
      step(32'hE0810003, 32'd5, 32'd7, 1, "R3");
      step(32'hE26A7031, 32'd10, 32'd0, 1, "R3");
      step(32'hE26A7031, 32'd100, 32'd0, 1, "R3");
      // R2 rotated immediates
      step(enc(1, 4'd13, 0, 4'd0, 4'd2, {4'd13, 8'd30}), 32'd0, 32'd0, 1, "R2");
      step(enc(1, 4'd13, 0, 4'd0, 4'd2, {4'd0, 8'hFF}), 32'd0, 32'd0, 1, "R2");
      step(enc(1, 4'd13, 0, 4'd0, 4'd2, {4'd1, 8'h03}), 32'd0, 32'd0, 1, "R2");
      step(enc(1, 4'd13, 0, 4'd0, 4'd2, {4'd15, 8'hAB}), 32'd0, 32'd0, 1, "R2");
      // R8 carry and overflow corners
      step(enc(0, 4'd4, 1, 4'd1, 4'd2, 12'd3), 32'hFFFF_FFFF, 32'd1, 1, "R8");
      step(enc(0, 4'd4, 1, 4'd1, 4'd2, 12'd3), 32'h7FFF_FFFF, 32'd1, 1, "R8");
      step(enc(0, 4'd2, 1, 4'd1, 4'd2, 12'd3), 32'd9, 32'd9, 1, "R8");
      step(enc(0, 4'd2, 1, 4'd1, 4'd2, 12'd3), 32'h8000_0000, 32'd1, 1, "R8");
      // R8 logical keeps C and V
      step(enc(0, 4'd0, 1, 4'd1, 4'd2, 12'd3), 32'hF0F0_0000, 32'h0F0F_0000, 1, "R8");
      // R5 carry chain: ADCS then SBCS consuming and rewriting carry
      step(enc(0, 4'd4, 1, 4'd1, 4'd2, 12'd3), 32'hFFFF_FFFF, 32'd2, 1, "R5");
      step(enc(0, 4'd5, 1, 4'd1, 4'd2, 12'd3), 32'd10, 32'd20, 1, "R5");
      step(enc(0, 4'd6, 1, 4'd1, 4'd2, 12'd3), 32'd5, 32'd5, 1, "R5");
      step(enc(0, 4'd7, 1, 4'd1, 4'd2, 12'd3), 32'd5, 32'd5, 1, "R5");
      // R7 no flag update without the set bit
      step(enc(0, 4'd2, 0, 4'd1, 4'd2, 12'd3), 32'd4, 32'd4, 1, "R7");
      // R6 compares update flags with set bit clear, never write
      step(enc(0, 4'd10, 0, 4'd1, 4'd2, 12'd3), 32'd1, 32'd2, 1, "R6");
      step(enc(0, 4'd11, 0, 4'd1, 4'd2, 12'd3), 32'hFFFF_FFFF, 32'd1, 1, "R6");
      step(enc(0, 4'd9, 0, 4'd1, 4'd2, 12'd3), 32'h55, 32'h55, 1, "R6");
      // R4 MOV/MVN ignore rn
      step(enc(0, 4'd13, 1, 4'd1, 4'd2, 12'd3), 32'hDEAD_BEEF, 32'd0, 1, "R4");
      step(enc(0, 4'd15, 1, 4'd1, 4'd2, 12'd3), 32'hDEAD_BEEF, 32'd0, 1, "R4");
      step(enc(0, 4'd14, 0, 4'd1, 4'd2, 12'd3), 32'hFF00_FF00, 32'h0F00_0F00, 1, "R4");
      // R9 unsupported: CMP-like word with bits 27:26 = 01
      step(32'hE5510000, 32'd0, 32'd0, 1, "R9");
      step(32'hEC900000, 32'd1, 32'd1, 1, "R9");
      // R11 invalid cycle with a flag-setting word
      step(enc(0, 4'd10, 1, 4'd1, 4'd2, 12'd3), 32'd0, 32'd0, 0, "R11");

      for (int n = 0; n < 600; n++) begin
         logic [3:0]  op = 4'($urandom);
         logic [31:0] w  = enc(1'($urandom), op, 1'($urandom), 4'($urandom),
                               4'($urandom), 12'($urandom));
         logic [31:0] a  = (n % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
         logic [31:0] m  = (n % 7 == 0) ? 32'h8000_0000 : $urandom;
         string       tg = (op[3:2] == 2'b10) ? "R6" :
                           (op inside {4'd0, 4'd1, 4'd12, 4'd13, 4'd14, 4'd15}) ? "R4" : "R5";
         if (n % 23 == 0) begin
            w[27:26] = 2'($urandom_range(3, 1));
            tg = "R9";
         end
         step(w, a, m, (n % 17 != 0), (n % 17 == 0) ? "R11" : tg);
      end

      // R10 reset mid-run clears flags
      step(enc(0, 4'd4, 1, 4'd1, 4'd2, 12'd3), 32'h8000_0000, 32'h8000_0000, 1, "R10");
      @(negedge clk);
      instr_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R10", "flags in reset", {28'd0, flags_nzcv}, 32'd0);
      m_f = 4'b0000;
      @(negedge clk);
      rst_n = 1'b1;
      step(enc(0, 4'd13, 0, 4'd1, 4'd2, 12'd3), 32'd0, 32'd0, 1, "R10");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule